// File: doc/BRIEF.md
# Learning Migration Decision Predictor

This block sits beside a core and rules on every memory access that a thread issues. When the address belongs to another core (a core miss), it answers whether the thread should send a word-sized remote request or move itself to the owning core. When the answer is to move, it also states how many main-stack and auxiliary-stack entries travel with the thread. The ruling comes from a small direct-mapped table keyed by the program counter. The table starts empty, so every core miss is at first served remotely.

The block learns by watching runs of consecutive accesses that go to the same home core. A run that grows long enough puts the program counter that opened it into the table. A run that is cut short removes it again. When a thread that left its native context comes back, it reports why it returned and how many local accesses it made away from home. Those reports tune the stored main-stack size up or down, or drop the entry. The home core of each address is computed outside the block and arrives as an input.

Top module: `mig_predictor`

## Requirements
- R1: After reset the table holds no entries, `dec_valid_o` and `dec_migrate_o` are low, and the first core miss is ruled remote.
- R2: Each access with `acc_valid_i` high gives exactly one decision with `dec_valid_o` high on the following clock cycle. A cycle with no access gives `dec_valid_o` low on the next cycle.
- R3: A decision migrates only if the access was a core miss and its PC hits the table. Any other decision is remote, with both sizes output as 0.
- R4: The run tracker counts consecutive same-home accesses starting from 1. Let θ be `theta_i`. An access to the same home while the count is below θ adds one to the count. An access to the same home while the count is at least θ writes the run's start PC into the table. For example, with θ=3, the fourth access of a run causes the insert.
- R5: A new entry holds main size 8 and auxiliary size 0. Inserting a PC that is already present keeps its learned sizes.
- R6: An access to a different home while the count is below θ invalidates the table entry of the old start PC. The tracker then restarts with the new home, the current PC and a count of 1.
- R7: A migrating core miss with `acc_guest_i` high outputs `acc_guest_main_i` and `acc_guest_aux_i` as the sizes, in place of the stored ones.
- R8: A native migration latches its PC. A return report with `ret_reason_i`=1 (overflow) reduces that entry's main size by 1, stopping at 1. A report with `ret_reason_i`=2 (underflow) raises it by 1, stopping at 16. Any other code leaves the size unchanged.
- R9: A return report whose `ret_local_cnt_i` is below θ removes the latched PC's entry. This takes priority over any size change.
- R10: The table index is PC bits [6:2] and the tag is PC bits [31:7]. Two PCs with the same index but different tags never hit each other's entry, and inserting one of them replaces the other.
- R11: θ is read from `theta_i` at each access, so changing it changes the run length needed for the next insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| theta_i | input | 8 | Run-length threshold θ |
| acc_valid_i | input | 1 | A memory access is presented |
| acc_pc_i | input | 32 | PC of the accessing instruction |
| acc_home_i | input | 7 | Home core ID of the address |
| acc_core_miss_i | input | 1 | The home core is not the current core |
| acc_guest_i | input | 1 | The thread runs in the guest context |
| acc_guest_main_i | input | 5 | Occupied main-stack entries in the guest context |
| acc_guest_aux_i | input | 4 | Occupied auxiliary-stack entries in the guest context |
| ret_valid_i | input | 1 | A return report from the thread arriving home |
| ret_reason_i | input | 2 | 1 = overflow, 2 = underflow, other = neither |
| ret_local_cnt_i | input | 8 | Local accesses made at the destination |
| dec_valid_o | output | 1 | A decision is presented |
| dec_migrate_o | output | 1 | 1 = migrate, 0 = remote access |
| dec_main_o | output | 5 | Main-stack entries to carry |
| dec_aux_o | output | 4 | Auxiliary-stack entries to carry |

## Verification
Runs are driven three ways: one home core held for θ+1 accesses, one held for fewer than θ before the home changes, and θ lowered partway through a run. Together they separate insertion, invalidation and threshold handling. Return reports are sent many times in a row in both directions, which shows both that sizes adjust step by step and that they stop at the bounds. A short-stay report that also carries an overflow code shows that removal takes priority over shrinking. A PC that aliases a trained entry separates tag matching from index-only matching, and a guest-context access shows that the supplied counts override the stored sizes.

// File: rtl/mig_pred_pkg.sv
package mig_pred_pkg;

    // Run-tracker request toward the table
    typedef enum logic [1:0] {
        TRK_NOP    = 2'd0,
        TRK_INSERT = 2'd1,
        TRK_INVAL  = 2'd2
    } trk_op_e;

    // Return-feedback request toward the table
    typedef enum logic [1:0] {
        FB_NOP    = 2'd0,
        FB_REMOVE = 2'd1,
        FB_SHRINK = 2'd2,
        FB_GROW   = 2'd3
    } fb_op_e;

    // Return reason codes on the report port
    localparam logic [1:0] REASON_OVERFLOW  = 2'd1;
    localparam logic [1:0] REASON_UNDERFLOW = 2'd2;

    // Default sizes for a fresh entry
    localparam int DEF_MAIN_SZ = 8;
    localparam int DEF_AUX_SZ  = 0;

endpackage

// File: rtl/mig_run_tracker.sv
module mig_run_tracker
    import mig_pred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int CORE_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [CORE_W-1:0] acc_home,
    input  logic [CNT_W-1:0]  theta,
    output trk_op_e           op,
    output logic [PC_W-1:0]   op_pc
);

    logic              live_q, live_d;
    logic [CORE_W-1:0] home_q, home_d;
    logic [CNT_W-1:0]  depth_q, depth_d;
    logic [PC_W-1:0]   start_q, start_d;

    always_comb begin
        op      = TRK_NOP;
        op_pc   = start_q;
        live_d  = live_q;
        home_d  = home_q;
        depth_d = depth_q;
        start_d = start_q;
        if (acc_valid) begin
            if (live_q && acc_home == home_q) begin
                if (depth_q < theta) depth_d = depth_q + 1'b1;
                else                 op      = TRK_INSERT;
            end else begin
                if (live_q && depth_q < theta) op = TRK_INVAL;
                live_d  = 1'b1;
                home_d  = acc_home;
                start_d = acc_pc;
                depth_d = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= 1'b0;
            home_q  <= '0;
            depth_q <= '0;
            start_q <= '0;
        end else begin
            live_q  <= live_d;
            home_q  <= home_d;
            depth_q <= depth_d;
            start_q <= start_d;
        end
    end

endmodule

// File: rtl/mig_table.sv
module mig_table
    import mig_pred_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int ALIGN    = 2,
    parameter int ENTRIES  = 32,
    parameter int MAIN_MAX = 16,
    parameter int AUX_MAX  = 8,
    parameter int MAIN_MIN = 1,
    parameter int DEF_MAIN = DEF_MAIN_SZ,
    parameter int DEF_AUX  = DEF_AUX_SZ,
    localparam int MAIN_W  = $clog2(MAIN_MAX + 1),
    localparam int AUX_W   = $clog2(AUX_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output logic [MAIN_W-1:0] lk_main,
    output logic [AUX_W-1:0]  lk_aux,
    input  trk_op_e           trk_op,
    input  logic [PC_W-1:0]   trk_pc,
    input  fb_op_e            fb_op,
    input  logic [PC_W-1:0]   fb_pc
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - ALIGN;
    localparam logic [MAIN_W-1:0] MAX_L = MAIN_W'(MAIN_MAX);
    localparam logic [MAIN_W-1:0] MIN_L = MAIN_W'(MAIN_MIN);

    typedef struct packed {
        logic              v;
        logic [TAG_W-1:0]  tag;
        logic [MAIN_W-1:0] main;
        logic [AUX_W-1:0]  aux;
    } ent_t;

    ent_t tbl_q [ENTRIES];

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return pc[ALIGN +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    ent_t lk_ent;
    always_comb begin
        lk_ent  = tbl_q[idx_of(lk_pc)];
        lk_hit  = lk_ent.v && lk_ent.tag == tag_of(lk_pc);
        lk_main = lk_ent.main;
        lk_aux  = lk_ent.aux;
    end

    // A tracker write that changes an entry wins over feedback on that index
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                logic trk_here, trk_match, fb_match, ins_eff, inv_eff;
                trk_here  = idx_of(trk_pc) == IDX_W'(i);
                trk_match = tbl_q[i].v && tbl_q[i].tag == tag_of(trk_pc);
                fb_match  = idx_of(fb_pc) == IDX_W'(i) && tbl_q[i].v
                            && tbl_q[i].tag == tag_of(fb_pc);
                ins_eff   = trk_here && trk_op == TRK_INSERT && !trk_match;
                inv_eff   = trk_here && trk_op == TRK_INVAL && trk_match;
                if (ins_eff) begin
                    tbl_q[i].v    <= 1'b1;
                    tbl_q[i].tag  <= tag_of(trk_pc);
                    tbl_q[i].main <= MAIN_W'(DEF_MAIN);
                    tbl_q[i].aux  <= AUX_W'(DEF_AUX);
                end else if (inv_eff) begin
                    tbl_q[i].v <= 1'b0;
                end else if (fb_match) begin
                    case (fb_op)
                        FB_REMOVE: tbl_q[i].v <= 1'b0;
                        FB_SHRINK: if (tbl_q[i].main > MIN_L) tbl_q[i].main <= tbl_q[i].main - 1'b1;
                        FB_GROW:   if (tbl_q[i].main < MAX_L) tbl_q[i].main <= tbl_q[i].main + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/mig_predictor.sv
module mig_predictor
    import mig_pred_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int CORE_W   = 7,
    parameter int CNT_W    = 8,
    parameter int ALIGN    = 2,
    parameter int ENTRIES  = 32,
    parameter int MAIN_MAX = 16,
    parameter int AUX_MAX  = 8,
    localparam int MAIN_W  = $clog2(MAIN_MAX + 1),
    localparam int AUX_W   = $clog2(AUX_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  theta_i,
    input  logic              acc_valid_i,
    input  logic [PC_W-1:0]   acc_pc_i,
    input  logic [CORE_W-1:0] acc_home_i,
    input  logic              acc_core_miss_i,
    input  logic              acc_guest_i,
    input  logic [MAIN_W-1:0] acc_guest_main_i,
    input  logic [AUX_W-1:0]  acc_guest_aux_i,
    input  logic              ret_valid_i,
    input  logic [1:0]        ret_reason_i,
    input  logic [CNT_W-1:0]  ret_local_cnt_i,
    output logic              dec_valid_o,
    output logic              dec_migrate_o,
    output logic [MAIN_W-1:0] dec_main_o,
    output logic [AUX_W-1:0]  dec_aux_o
);

    trk_op_e           trk_op;
    logic [PC_W-1:0]   trk_pc;
    fb_op_e            fb_op;
    logic              lk_hit;
    logic [MAIN_W-1:0] lk_main;
    logic [AUX_W-1:0]  lk_aux;
    logic              mig_live_q;
    logic [PC_W-1:0]   mig_pc_q;
    logic              go_migrate;

    mig_run_tracker #(.PC_W(PC_W), .CORE_W(CORE_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid_i), .acc_pc(acc_pc_i), .acc_home(acc_home_i),
        .theta(theta_i), .op(trk_op), .op_pc(trk_pc)
    );

    mig_table #(
        .PC_W(PC_W), .ALIGN(ALIGN), .ENTRIES(ENTRIES),
        .MAIN_MAX(MAIN_MAX), .AUX_MAX(AUX_MAX)
    ) u_tbl (
        .clk(clk), .rst(rst),
        .lk_pc(acc_pc_i), .lk_hit(lk_hit), .lk_main(lk_main), .lk_aux(lk_aux),
        .trk_op(trk_op), .trk_pc(trk_pc),
        .fb_op(fb_op), .fb_pc(mig_pc_q)
    );

    // Return feedback: a short stay removes, otherwise the reason tunes size
    always_comb begin
        fb_op = FB_NOP;
        if (ret_valid_i && mig_live_q) begin
            if (ret_local_cnt_i < theta_i)           fb_op = FB_REMOVE;
            else if (ret_reason_i == REASON_OVERFLOW)  fb_op = FB_SHRINK;
            else if (ret_reason_i == REASON_UNDERFLOW) fb_op = FB_GROW;
        end
    end

    assign go_migrate = acc_valid_i && acc_core_miss_i && lk_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid_o   <= 1'b0;
            dec_migrate_o <= 1'b0;
            dec_main_o    <= '0;
            dec_aux_o     <= '0;
            mig_live_q    <= 1'b0;
            mig_pc_q      <= '0;
        end else begin
            dec_valid_o   <= acc_valid_i;
            dec_migrate_o <= go_migrate;
            dec_main_o    <= !go_migrate ? '0 : (acc_guest_i ? acc_guest_main_i : lk_main);
            dec_aux_o     <= !go_migrate ? '0 : (acc_guest_i ? acc_guest_aux_i : lk_aux);
            if (go_migrate && !acc_guest_i) begin
                mig_live_q <= 1'b1;
                mig_pc_q   <= acc_pc_i;
            end
        end
    end

endmodule

// File: rtl/mig_predictor_chk.sv
module mig_predictor_chk #(
    parameter int CNT_W    = 8,
    parameter int MAIN_MAX = 16,
    parameter int AUX_MAX  = 8,
    localparam int MAIN_W  = $clog2(MAIN_MAX + 1),
    localparam int AUX_W   = $clog2(AUX_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid_i,
    input logic              acc_core_miss_i,
    input logic              acc_guest_i,
    input logic [MAIN_W-1:0] acc_guest_main_i,
    input logic [AUX_W-1:0]  acc_guest_aux_i,
    input logic              dec_valid_o,
    input logic              dec_migrate_o,
    input logic [MAIN_W-1:0] dec_main_o,
    input logic [AUX_W-1:0]  dec_aux_o
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dec_valid_o && !dec_migrate_o));

    a_r2_one_decision: assert property (@(posedge clk) disable iff (rst)
        acc_valid_i |=> dec_valid_o);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |=> !dec_valid_o);

    a_r3_local_stays: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && !acc_core_miss_i) |=> !dec_migrate_o);

    a_r3_remote_sizes: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_o && !dec_migrate_o) |-> (dec_main_o == '0 && dec_aux_o == '0));

    a_r8_native_bounds: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_core_miss_i && !acc_guest_i) |=>
        (!dec_migrate_o || (dec_main_o >= 1 && dec_main_o <= MAIN_W'(MAIN_MAX)
                            && dec_aux_o <= AUX_W'(AUX_MAX))));

    a_r7_guest_sizes: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_core_miss_i && acc_guest_i) |=>
        (!dec_migrate_o || (dec_main_o == $past(acc_guest_main_i)
                            && dec_aux_o == $past(acc_guest_aux_i))));

endmodule

bind mig_predictor mig_predictor_chk #(
    .CNT_W(CNT_W), .MAIN_MAX(MAIN_MAX), .AUX_MAX(AUX_MAX)
) u_chk (
    .clk(clk), .rst(rst),
    .acc_valid_i(acc_valid_i), .acc_core_miss_i(acc_core_miss_i),
    .acc_guest_i(acc_guest_i), .acc_guest_main_i(acc_guest_main_i),
    .acc_guest_aux_i(acc_guest_aux_i),
    .dec_valid_o(dec_valid_o), .dec_migrate_o(dec_migrate_o),
    .dec_main_o(dec_main_o), .dec_aux_o(dec_aux_o)
);

// File: tb/mig_predictor_test.sv
module mig_predictor_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  theta_i = 8'd3;
    logic        acc_valid_i = 1'b0;
    logic [31:0] acc_pc_i = '0;
    logic [6:0]  acc_home_i = '0;
    logic        acc_core_miss_i = 1'b0;
    logic        acc_guest_i = 1'b0;
    logic [4:0]  acc_guest_main_i = '0;
    logic [3:0]  acc_guest_aux_i = '0;
    logic        ret_valid_i = 1'b0;
    logic [1:0]  ret_reason_i = '0;
    logic [7:0]  ret_local_cnt_i = '0;
    logic        dec_valid_o, dec_migrate_o;
    logic [4:0]  dec_main_o;
    logic [3:0]  dec_aux_o;

    int checks = 0;
    int fails  = 0;
    logic       got_valid, got_mig;
    logic [4:0] got_main;
    logic [3:0] got_aux;

    localparam logic [31:0] PC_A = 32'h0000_0100; // index 0, tag 2
    localparam logic [31:0] PC_B = 32'h0000_0180; // index 0, tag 3
    localparam logic [31:0] PC_C = 32'h0000_0204; // index 1, tag 4
    localparam logic [31:0] PC_D = 32'h0000_0300; // index 0, tag 6

    always #4 clk = ~clk; // 125 MHz

    mig_predictor uut (
        .clk(clk), .rst(rst), .theta_i(theta_i),
        .acc_valid_i(acc_valid_i), .acc_pc_i(acc_pc_i), .acc_home_i(acc_home_i),
        .acc_core_miss_i(acc_core_miss_i), .acc_guest_i(acc_guest_i),
        .acc_guest_main_i(acc_guest_main_i), .acc_guest_aux_i(acc_guest_aux_i),
        .ret_valid_i(ret_valid_i), .ret_reason_i(ret_reason_i),
        .ret_local_cnt_i(ret_local_cnt_i),
        .dec_valid_o(dec_valid_o), .dec_migrate_o(dec_migrate_o),
        .dec_main_o(dec_main_o), .dec_aux_o(dec_aux_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] pc, input logic [6:0] home,
                          input logic miss, input logic guest,
                          input logic [4:0] gm, input logic [3:0] ga);
        @(negedge clk);
        acc_pc_i = pc; acc_home_i = home; acc_core_miss_i = miss;
        acc_guest_i = guest; acc_guest_main_i = gm; acc_guest_aux_i = ga;
        acc_valid_i = 1'b1;
        @(negedge clk);
        got_valid = dec_valid_o; got_mig = dec_migrate_o;
        got_main = dec_main_o; got_aux = dec_aux_o;
        acc_valid_i = 1'b0;
    endtask

    task automatic report(input logic [1:0] reason, input logic [7:0] cnt);
        @(negedge clk);
        ret_reason_i = reason; ret_local_cnt_i = cnt; ret_valid_i = 1'b1;
        @(negedge clk);
        ret_valid_i = 1'b0;
    endtask

    task automatic expect_dec(input string req, input int mig, input int m, input int a);
        check({req, " valid"}, got_valid, 1);
        check({req, " migrate"}, got_mig, mig);
        check({req, " main"}, got_main, m);
        check({req, " aux"}, got_aux, a);
    endtask

    task automatic t_reset;
        check("R1 valid after reset", dec_valid_o, 0);
        check("R1 migrate after reset", dec_migrate_o, 0);
    endtask

    task automatic t_learn_run; // theta 3, home 5
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R1 empty table remote", 0, 0, 0);
        access(PC_A + 4, 7'd5, 1, 0, 0, 0);
        expect_dec("R3 miss remote", 0, 0, 0);
        access(PC_A + 8, 7'd5, 1, 0, 0, 0);
        access(PC_A + 12, 7'd5, 1, 0, 0, 0); // fourth: R4 insert
        expect_dec("R4 not yet visible", 0, 0, 0);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R4 R5 learned default", 1, 8, 0);
    endtask

    task automatic t_feedback;
        report(2'd1, 8'd5);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R8 overflow shrink", 1, 7, 0);
        report(2'd2, 8'd5);
        report(2'd2, 8'd5);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R8 underflow grow", 1, 9, 0);
        for (int i = 0; i < 10; i++) report(2'd2, 8'd5);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R8 R5 ceiling kept", 1, 16, 0);
        report(2'd0, 8'd5);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R8 neutral reason", 1, 16, 0);
        for (int i = 0; i < 20; i++) report(2'd1, 8'd5);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R8 floor", 1, 1, 0);
    endtask

    task automatic t_guest;
        access(PC_A, 7'd5, 1, 1, 5'd11, 4'd3);
        expect_dec("R7 guest override", 1, 11, 3);
    endtask

    task automatic t_alias_miss;
        access(PC_B, 7'd5, 1, 0, 0, 0);
        expect_dec("R10 alias misses", 0, 0, 0);
    endtask

    task automatic t_remove;
        report(2'd1, 8'd2); // short stay plus overflow: R9 remove wins
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R9 removed", 0, 0, 0);
        access(PC_A, 7'd5, 1, 0, 0, 0);
        expect_dec("R9 R5 relearned fresh", 1, 8, 0);
    endtask

    task automatic t_theta_break;
        theta_i = 8'd2;
        access(PC_C, 7'd9, 1, 0, 0, 0);
        access(PC_C + 4, 7'd9, 1, 0, 0, 0);
        access(PC_C + 8, 7'd9, 1, 0, 0, 0); // third access inserts with theta 2
        theta_i = 8'd5;
        access(PC_C, 7'd9, 1, 0, 0, 0);
        expect_dec("R11 shorter run learned", 1, 8, 0);
        access(PC_D, 7'd12, 1, 0, 0, 0); // short run breaks: R6 invalidate C
        expect_dec("R6 new home remote", 0, 0, 0);
        access(PC_C, 7'd12, 1, 0, 0, 0);
        expect_dec("R6 old start invalidated", 0, 0, 0);
    endtask

    task automatic t_replace;
        theta_i = 8'd2;
        access(PC_B, 7'd7, 1, 0, 0, 0);
        access(PC_B + 4, 7'd7, 1, 0, 0, 0);
        access(PC_B + 8, 7'd7, 1, 0, 0, 0);
        access(PC_B, 7'd7, 1, 0, 0, 0);
        expect_dec("R10 alias inserted", 1, 8, 0);
        access(PC_A, 7'd7, 1, 0, 0, 0);
        expect_dec("R10 old entry replaced", 0, 0, 0);
        access(PC_B, 7'd7, 0, 0, 0, 0);
        expect_dec("R3 local hit stays", 0, 0, 0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check("R2 idle no decision", dec_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_learn_run;
        t_feedback;
        t_guest;
        t_alias_miss;
        t_remove;
        t_theta_break;
        t_replace;
        t_idle;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule